// File: doc/BRIEF.md
# DRAM Strobe Timing Compliance Monitor

This block watches the four active-low control strobes of an asynchronous DRAM: row strobe, column strobe, write enable and output enable. All four are sampled on a fast clock. The monitor measures the time between their edges as whole clock counts. A rule broken by the controller or the memory model sets a bit in a sticky error vector. Every threshold is a parameter in clock cycles. The values are rounded up from nanoseconds so that a real violation always shows up as a count below the limit.

The monitor also classifies every row-strobe cycle by where the write-enable fall sits against the column and row strobe falls. The class is read, early write, read-modify-write, or delayed write with undefined output data. The class is reported with a one-cycle valid pulse after the row strobe returns high. The class of the previous cycle picks the cycle-time limit for the next row strobe fall.

Top module: `dram_strobe_monitor`

## Requirements
- R1: One cycle after a sampled rising edge of `row_stb_n`, `cls_valid` is high for exactly one cycle and `cls` holds the class of that cycle. The class codes are: 0 = read, 1 = early write, 2 = read-modify-write, 3 = indeterminate delayed write. A cycle with no column-strobe fall is a read. A cycle in which write enable is high at the column fall and never falls under both strobes is also a read.
- R2: A cycle is an early write (code 1) when `wr_en_n` is sampled low in the cycle where the first `col_stb_n` fall inside a row-low period is sampled.
- R3: A cycle is a delayed write when `wr_en_n` falls while both strobes are low after a column fall that saw it high. It is a read-modify-write (code 2) when that fall is at least CWD_MIN cycles after the column fall and at least RWD_MIN cycles after the row fall. Otherwise it is indeterminate (code 3), and `err[10]` is set.
- R4: `err[0]` is set when a row-low period is shorter than RAS_MIN cycles. `err[1]` is set when it is longer than RAS_MAX cycles.
- R5: `err[2]` is set when a column-low period is shorter than CAS_MIN cycles. `err[3]` is set when it is longer than CAS_MAX cycles.
- R6: `err[4]` is set when two row falls are closer than RC_MIN cycles. The limit is RWC_MIN cycles instead when the earlier cycle was a read-modify-write.
- R7: `err[5]` is set in a read when `wr_en_n` is low at the column rise (an edge in the same sample counts as low). The bit is set only when write enable also went low before RRH_MIN cycles had passed since the row rise.
- R8: In any write class, `err[6]` is set when the column rise comes less than CWL_MIN cycles after the write-enable fall. `err[7]` is set when the row rise comes less than RWL_MIN cycles after it.
- R9: `err[8]` is set when a `wr_en_n` low pulse lasts fewer than WP_MIN cycles.
- R10: `err[9]` is set in a read when `out_en_n` is low at the row rise and fell fewer than ORH_MIN cycles before it.
- R11: All error bits are zero after reset. They stay set until `clr` is sampled high, which clears them. A rule hit in the same cycle as `clr` still sets its bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Clears the sticky error vector |
| row_stb_n | input | 1 | Row address strobe, active low |
| col_stb_n | input | 1 | Column address strobe, active low |
| wr_en_n | input | 1 | Write enable, active low |
| out_en_n | input | 1 | Output enable, active low |
| err | output | 11 | Sticky rule-violation flags |
| cls_valid | output | 1 | Pulse marking a new cycle class |
| cls | output | 2 | Class of the cycle that just ended |

## Verification
The hardest case to reach is the read-hold rule. Its bit needs both conditions to fail: write enable must be low at the column rise, and it must also have dropped too soon after the row rise. That only happens when the column strobe outlives the row strobe and write enable falls in a narrow window around both rises. The bench reaches it by stretching the column-low time past the row rise. It then sweeps the write-enable fall across the few cycles before and at the column rise. A wide sweep of the write-enable fall position across one fixed cycle walks the class through read, early write, indeterminate and read-modify-write, including the exact boundary samples.

// File: rtl/dram_strobe_monitor.sv
module dram_strobe_monitor #(
  parameter int RAS_MIN = 10,
  parameter int RAS_MAX = 2000,
  parameter int CAS_MIN = 3,
  parameter int CAS_MAX = 2000,
  parameter int RC_MIN  = 18,
  parameter int RWC_MIN = 26,
  parameter int CWD_MIN = 6,
  parameter int RWD_MIN = 13,
  parameter int RRH_MIN = 2,
  parameter int CWL_MIN = 3,
  parameter int RWL_MIN = 3,
  parameter int WP_MIN  = 2,
  parameter int ORH_MIN = 3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clr,
  input  logic        row_stb_n,
  input  logic        col_stb_n,
  input  logic        wr_en_n,
  input  logic        out_en_n,
  output logic [10:0] err,
  output logic        cls_valid,
  output logic [1:0]  cls
);

  localparam int LIM_A   = (RAS_MAX > CAS_MAX) ? RAS_MAX : CAS_MAX;
  localparam int LIM_B   = (RWC_MIN > RC_MIN) ? RWC_MIN : RC_MIN;
  localparam int LIM_C   = (RWD_MIN > CWD_MIN) ? RWD_MIN : CWD_MIN;
  localparam int LIM_AB  = (LIM_A > LIM_B) ? LIM_A : LIM_B;
  localparam int AGE_MAX = ((LIM_AB > LIM_C) ? LIM_AB : LIM_C) + 1;
  localparam int AW      = $clog2(AGE_MAX + 1);

  localparam logic [AW-1:0] AMAX    = AW'(AGE_MAX);
  localparam logic [AW-1:0] T_RASLO = AW'(RAS_MIN);
  localparam logic [AW-1:0] T_RASHI = AW'(RAS_MAX);
  localparam logic [AW-1:0] T_CASLO = AW'(CAS_MIN);
  localparam logic [AW-1:0] T_CASHI = AW'(CAS_MAX);
  localparam logic [AW-1:0] T_RC    = AW'(RC_MIN);
  localparam logic [AW-1:0] T_RWC   = AW'(RWC_MIN);
  localparam logic [AW-1:0] T_CWD   = AW'(CWD_MIN);
  localparam logic [AW-1:0] T_RWD   = AW'(RWD_MIN);
  localparam logic [AW-1:0] T_RRH   = AW'(RRH_MIN);
  localparam logic [AW-1:0] T_CWL   = AW'(CWL_MIN);
  localparam logic [AW-1:0] T_RWL   = AW'(RWL_MIN);
  localparam logic [AW-1:0] T_WP    = AW'(WP_MIN);
  localparam logic [AW-1:0] T_ORH   = AW'(ORH_MIN);

  localparam logic [1:0] C_READ  = 2'd0;
  localparam logic [1:0] C_EARLY = 2'd1;
  localparam logic [1:0] C_RMW   = 2'd2;
  localparam logic [1:0] C_INDET = 2'd3;

  function automatic logic [AW-1:0] age_nx(input logic ev, input logic [AW-1:0] a);
    if (ev) return AW'(1);
    if (a < AMAX) return a + 1'b1;
    return a;
  endfunction

  logic r_row, r_col, r_wr, r_oe;
  logic [AW-1:0] a_rowf, a_rowr, a_colf, a_wrf, a_oef;
  logic seen_col, rd_act, wlow_ok, cwl_pend, rwl_pend, prev_rmw;
  logic [1:0] cls_cur;
  logic [10:0] hit;

  wire row_fall = r_row & ~row_stb_n;
  wire row_rise = ~r_row & row_stb_n;
  wire col_fall = r_col & ~col_stb_n;
  wire col_rise = ~r_col & col_stb_n;
  wire wr_fall  = r_wr & ~wr_en_n;
  wire wr_rise  = ~r_wr & wr_en_n;
  wire oe_fall  = r_oe & ~out_en_n;

  wire [AW-1:0] wr_age  = wr_fall ? '0 : a_wrf;
  wire [AW-1:0] oe_age  = oe_fall ? '0 : a_oef;
  wire [AW-1:0] rowr_age = row_rise ? '0 : a_rowr;

  wire rrh_ok    = row_stb_n && (rowr_age >= T_RRH);
  wire col_first = col_fall && !row_stb_n && !seen_col;
  wire dly_wr    = wr_fall && !row_stb_n && !row_fall && !col_stb_n && !col_fall &&
                   seen_col && (cls_cur == C_READ);
  wire rmw_ok    = (a_colf >= T_CWD) && (a_rowf >= T_RWD);
  wire rch_bad   = col_rise && rd_act && !wr_en_n && !(wr_fall ? rrh_ok : wlow_ok);

  always_comb begin
    hit     = '0;
    hit[0]  = row_rise && (a_rowf < T_RASLO);
    hit[1]  = !row_stb_n && !row_fall && (a_rowf >= T_RASHI);
    hit[2]  = col_rise && (a_colf < T_CASLO);
    hit[3]  = !col_stb_n && !col_fall && (a_colf >= T_CASHI);
    hit[4]  = row_fall && (a_rowf < (prev_rmw ? T_RWC : T_RC));
    hit[5]  = rch_bad;
    hit[6]  = col_rise && cwl_pend && (wr_age < T_CWL);
    hit[7]  = row_rise && rwl_pend && (wr_age < T_RWL);
    hit[8]  = wr_rise && (a_wrf < T_WP);
    hit[9]  = row_rise && (cls_cur == C_READ) && !out_en_n && (oe_age < T_ORH);
    hit[10] = dly_wr && !rmw_ok;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      r_row <= 1'b1; r_col <= 1'b1; r_wr <= 1'b1; r_oe <= 1'b1;
      a_rowf <= AMAX; a_rowr <= AMAX; a_colf <= AMAX; a_wrf <= AMAX; a_oef <= AMAX;
      seen_col <= 1'b0; rd_act <= 1'b0; wlow_ok <= 1'b0;
      cwl_pend <= 1'b0; rwl_pend <= 1'b0; prev_rmw <= 1'b0;
      cls_cur <= C_READ;
      err <= '0; cls_valid <= 1'b0; cls <= C_READ;
    end else begin
      r_row <= row_stb_n; r_col <= col_stb_n; r_wr <= wr_en_n; r_oe <= out_en_n;
      a_rowf <= age_nx(row_fall, a_rowf);
      a_rowr <= age_nx(row_rise, a_rowr);
      a_colf <= age_nx(col_fall, a_colf);
      a_wrf  <= age_nx(wr_fall, a_wrf);
      a_oef  <= age_nx(oe_fall, a_oef);

      if (row_fall) begin
        seen_col <= 1'b0; cls_cur <= C_READ; cwl_pend <= 1'b0; rwl_pend <= 1'b0;
      end
      if (col_first) begin
        seen_col <= 1'b1;
        if (!wr_en_n) begin
          cls_cur <= C_EARLY; cwl_pend <= 1'b1; rwl_pend <= 1'b1; rd_act <= 1'b0;
        end else begin
          rd_act <= 1'b1;
        end
      end
      if (dly_wr) begin
        cls_cur  <= rmw_ok ? C_RMW : C_INDET;
        cwl_pend <= 1'b1; rwl_pend <= 1'b1; rd_act <= 1'b0;
      end
      if (wr_fall && row_stb_n && !col_stb_n && rd_act) wlow_ok <= rrh_ok;
      if (col_rise) begin
        rd_act <= 1'b0; cwl_pend <= 1'b0;
      end
      if (row_rise) begin
        rwl_pend <= 1'b0;
        prev_rmw <= (cls_cur == C_RMW);
        cls      <= cls_cur;
      end
      cls_valid <= row_rise;
      err <= (clr ? '0 : err) | hit;
    end
  end

endmodule

// File: rtl/dram_strobe_monitor_sva.sv
module dram_strobe_monitor_sva #(
  parameter int RAS_MIN = 10,
  parameter int CAS_MIN = 3
) (
  input logic        clk,
  input logic        rst_n,
  input logic        clr,
  input logic        row_stb_n,
  input logic        col_stb_n,
  input logic [10:0] err,
  input logic        cls_valid
);
  localparam logic [15:0] L_ROW = 16'(RAS_MIN);
  localparam logic [15:0] L_COL = 16'(CAS_MIN);

  logic p_row, p_col;
  logic [15:0] row_lo, col_lo;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p_row <= 1'b1; p_col <= 1'b1; row_lo <= '0; col_lo <= '0;
    end else begin
      p_row  <= row_stb_n;
      p_col  <= col_stb_n;
      row_lo <= row_stb_n ? '0 : ((row_lo != 16'hFFFF) ? row_lo + 1'b1 : row_lo);
      col_lo <= col_stb_n ? '0 : ((col_lo != 16'hFFFF) ? col_lo + 1'b1 : col_lo);
    end
  end

  wire row_up = !p_row && row_stb_n;
  wire col_up = !p_col && col_stb_n;

  assert_valid_after_rise_R1: assert property (@(posedge clk) disable iff (!rst_n)
    row_up |=> cls_valid);
  assert_valid_only_after_rise_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !row_up |=> !cls_valid);
  assert_row_short_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (row_up && row_lo < L_ROW) |=> err[0]);
  assert_col_short_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (col_up && col_lo < L_COL) |=> err[2]);
  assert_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> ((err & $past(err)) == $past(err)));
endmodule

bind dram_strobe_monitor dram_strobe_monitor_sva #(.RAS_MIN(RAS_MIN), .CAS_MIN(CAS_MIN)) u_sva (
  .clk(clk), .rst_n(rst_n), .clr(clr), .row_stb_n(row_stb_n), .col_stb_n(col_stb_n),
  .err(err), .cls_valid(cls_valid)
);

// File: tb/dram_strobe_monitor_tb.sv
`timescale 1ns/1ps
module dram_strobe_monitor_tb;
  localparam int RAS_MIN = 10, RAS_MAX = 40, CAS_MIN = 3, CAS_MAX = 30;
  localparam int RC_MIN = 18, RWC_MIN = 26, CWD_MIN = 6, RWD_MIN = 13, RRH_MIN = 2;
  localparam int CWL_MIN = 3, RWL_MIN = 3, WP_MIN = 2, ORH_MIN = 3;

  logic clk = 1'b0, rst_n = 1'b0, clr = 1'b0;
  logic row_stb_n = 1'b1, col_stb_n = 1'b1, wr_en_n = 1'b1, out_en_n = 1'b1;
  logic [10:0] err;
  logic cls_valid;
  logic [1:0] cls;

  dram_strobe_monitor #(
    .RAS_MIN(RAS_MIN), .RAS_MAX(RAS_MAX), .CAS_MIN(CAS_MIN), .CAS_MAX(CAS_MAX),
    .RC_MIN(RC_MIN), .RWC_MIN(RWC_MIN), .CWD_MIN(CWD_MIN), .RWD_MIN(RWD_MIN),
    .RRH_MIN(RRH_MIN), .CWL_MIN(CWL_MIN), .RWL_MIN(RWL_MIN), .WP_MIN(WP_MIN),
    .ORH_MIN(ORH_MIN)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .clr(clr), .row_stb_n(row_stb_n), .col_stb_n(col_stb_n),
    .wr_en_n(wr_en_n), .out_en_n(out_en_n), .err(err), .cls_valid(cls_valid), .cls(cls)
  );

  always #2.5 clk = ~clk;

  int n_chk = 0, n_err = 0, vcnt = 0, last_cls = 0, cyc = 0;
  int last_fall = -100000;
  bit prev_rmw = 1'b0;
  logic [10:0] exp_acc = '0;

  always @(negedge clk) if (cls_valid) begin vcnt++; last_cls = int'(cls); end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic string bit_tag(input int b);
    case (b)
      0, 1: return "R4 row width";
      2, 3: return "R5 column width";
      4: return "R6 cycle time";
      5: return "R7 read hold";
      6, 7: return "R8 write hold";
      8: return "R9 write pulse";
      9: return "R10 output-enable hold";
      default: return "R3 indeterminate flag";
    endcase
  endfunction

  task automatic run_cyc(input int L, input int c0, input int cl, input int w0, input int wl,
                         input int o0, input int ol, input int gap, input bit do_clr);
    int last_p, v0, r, ecls, spacing, lim;
    bit hc, wr;
    logic [10:0] e;
    last_p = L;
    if (c0 + cl > last_p) last_p = c0 + cl;
    if (wl > 0 && w0 + wl > last_p) last_p = w0 + wl;
    if (ol > 0 && o0 + ol > last_p) last_p = o0 + ol;
    last_p += gap;
    v0 = vcnt;
    spacing = 0;
    for (int k = -4; k < last_p; k++) begin
      @(negedge clk);
      cyc++;
      if (k == 0) begin spacing = cyc - last_fall; last_fall = cyc; end
      clr       = do_clr && (k == -4);
      row_stb_n = !(k >= 0 && k < L);
      col_stb_n = !(cl > 0 && k >= c0 && k < c0 + cl);
      wr_en_n   = !(wl > 0 && k >= w0 && k < w0 + wl);
      out_en_n  = !(ol > 0 && k >= o0 && k < o0 + ol);
    end
    @(negedge clk);
    cyc++;
    clr = 1'b0;
    hc = (cl > 0);
    r = c0 + cl;
    if (!hc) ecls = 0;
    else if (wl > 0 && w0 <= c0 && w0 + wl > c0) ecls = 1;
    else if (wl > 0 && w0 > c0 && w0 < r && w0 < L && w0 > 0)
      ecls = (w0 - c0 >= CWD_MIN && w0 >= RWD_MIN) ? 2 : 3;
    else ecls = 0;
    wr = (ecls != 0);
    lim = prev_rmw ? RWC_MIN : RC_MIN;
    e = '0;
    e[0]  = (L < RAS_MIN);
    e[1]  = (L > RAS_MAX);
    e[2]  = hc && (cl < CAS_MIN);
    e[3]  = (cl > CAS_MAX);
    e[4]  = (spacing < lim);
    e[5]  = (ecls == 0) && hc && wl > 0 && r >= w0 && r < w0 + wl && (w0 - L < RRH_MIN);
    e[6]  = wr && (r - w0 < CWL_MIN);
    e[7]  = wr && (L - w0 < RWL_MIN);
    e[8]  = (wl > 0) && (wl < WP_MIN);
    e[9]  = (ecls == 0) && ol > 0 && L >= o0 && L < o0 + ol && (L - o0 < ORH_MIN);
    e[10] = (ecls == 3);
    exp_acc = do_clr ? e : (exp_acc | e);
    prev_rmw = (ecls == 2);
    chk(vcnt == v0 + 1, "R1 valid pulse count", vcnt - v0, 1);
    chk(last_cls == ecls, (ecls == 1) ? "R2 class" : (ecls >= 2) ? "R3 class" : "R1 class",
        last_cls, ecls);
    for (int b = 0; b < 11; b++)
      chk(err[b] == exp_acc[b], bit_tag(b), int'(err[b]), int'(exp_acc[b]));
  endtask

  initial begin
    #(200000 * 5);
    n_err++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    chk(err == 11'd0, "R11 reset error vector", int'(err), 0);
    chk(cls_valid == 1'b0, "R1 reset valid", int'(cls_valid), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    cyc += 3;
    // R1 R4 R5: plain reads over row and column widths
    for (int L = 8; L <= 14; L++)
      for (int cl = 1; cl <= 5; cl++) run_cyc(L, 2, cl, 0, 0, 0, 0, 20, 1'b1);
    // R2 R3 R8 R9 R7: write-enable fall position sweep
    for (int w0 = -2; w0 <= 18; w0++)
      for (int wi = 0; wi < 4; wi++)
        run_cyc(20, 3, 12, w0, (wi == 3) ? 8 : wi + 1, 0, 0, 20, 1'b1);
    // R7: column outlives row, write enable falls near the column rise
    for (int cl = 10; cl <= 16; cl++)
      for (int dw = 0; dw <= 3; dw++) run_cyc(12, 2, cl, 2 + cl - dw, dw + 3, 0, 0, 20, 1'b1);
    // R10: output-enable fall position sweep
    for (int o0 = 5; o0 <= 13; o0++) begin
      run_cyc(12, 2, 4, 0, 0, o0, 1, 20, 1'b1);
      run_cyc(12, 2, 4, 0, 0, o0, 3, 20, 1'b1);
      run_cyc(12, 2, 4, 0, 0, o0, 10, 20, 1'b1);
    end
    // R6: cycle spacing after read-modify-write and after read
    for (int g = 2; g <= 10; g++) begin
      run_cyc(15, 2, 12, 13, 1, 0, 0, g, 1'b1);
      run_cyc(10, 2, 3, 0, 0, 0, 0, g, 1'b1);
    end
    // R4 R5: maximum widths, at and beyond the limit
    run_cyc(40, 2, 30, 0, 0, 0, 0, 20, 1'b1);
    run_cyc(42, 2, 32, 0, 0, 0, 0, 20, 1'b1);
    // R11: error persists without clear, then clears
    run_cyc(5, 2, 2, 0, 0, 0, 0, 30, 1'b1);
    run_cyc(12, 2, 4, 0, 0, 0, 0, 20, 1'b0);
    run_cyc(12, 2, 4, 0, 0, 0, 0, 20, 1'b1);
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule